// File: doc/BRIEF.md
# Fused Multiply-Add Normalize and Round Stage

This block sits after the adder of a fused multiply-add datapath. It takes the unrounded sum significand and its exponent and sign, together with the side sticky bit X' that the alignment shifter produced. It returns a normalized 53-bit significand rounded to nearest even, with the adjusted exponent and the final sign, and three status flags that describe the finished fused result. The negated multiply-add and negated multiply-subtract forms are marked by one opcode flag, and that flag flips the final sign.

The sum is `SUM_W` bits wide. Its top bit carries weight 2 and the next bit carries weight 1 relative to `in_exp`. The block counts leading zeros across the whole sum and shifts them out to the left. X' is not part of this shift and only feeds the sticky bit. With the normalized vector numbered from 0 at the leading one, the first 53 bits form the result, bit 53 is guard, bit 54 is round, and every later bit ORed with X' forms sticky.

Both data sides use valid/ready. A transfer happens on a rising edge where valid and ready are both high. The producer must hold its data stable while valid is high and ready is low. `in_ready` depends combinationally on `out_ready`. The block holds two results internally: a normalize stage and a round stage. A stalled output freezes both stages and drops no item.

Top module: `fma_norm_round`

## Requirements
- R1: An item accepted on a rising edge appears on the output after the second rising edge that follows, provided `out_ready` stays high. While reset is active, `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, every output field holds its value. Once both internal stages are full, `in_ready` drops. Items leave in the order they were accepted, and none is lost.
- R3: For a nonzero sum, the top bit of `out_sig` is 1. `out_exp` equals `in_exp + 1 - z` modulo 2^EXP_W, where z is the count of leading zeros of `in_sum`. A sum whose top (weight-2) bit is set therefore gives `in_exp + 1`.
- R4: Counting from 0 at the leading one, `out_guard` is bit 53 and `out_round` is bit 54 of the shifted sum.
- R5: `out_sticky` is the OR of all shifted-sum bits after the round bit, ORed with `in_xbit`. X' never moves into the result, guard or round positions.
- R6: The result is incremented exactly when guard is set and at least one of round, sticky or the pre-round result LSB is set. `out_rounded_up` reports this increment.
- R7: If the increment carries out of 53 bits, `out_sig` becomes a 1 followed by zeros and `out_exp` goes up by one more.
- R8: For a nonzero sum, `out_sign` equals `in_sign` XOR `in_neg`.
- R9: An all-zero `in_sum` gives `out_zero` = 1, `out_sig` = 0, `out_exp` = 0 and `out_sign` = 0, whatever the sign and opcode flag are. In this case `out_inexact` equals `in_xbit`.
- R10: `out_inexact` is set exactly when guard, round or sticky is set. `out_zero` is set only for a zero result. All flags describe the final rounded result only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_sum | input | SUM_W | Adder sum; top bit has weight 2 |
| in_xbit | input | 1 | Sticky bit X' from the alignment shift |
| in_exp | input | EXP_W | Exponent of the sum |
| in_sign | input | 1 | Sign of the sum |
| in_neg | input | 1 | Negated multiply-add/subtract form |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | MANT_W | Rounded normalized significand |
| out_exp | output | EXP_W | Final exponent |
| out_sign | output | 1 | Final sign |
| out_guard | output | 1 | Guard bit before rounding |
| out_round | output | 1 | Round bit before rounding |
| out_sticky | output | 1 | Sticky bit before rounding |
| out_inexact | output | 1 | Result is inexact |
| out_rounded_up | output | 1 | Rounding incremented the significand |
| out_zero | output | 1 | Result is exact zero |

## Verification
Every result field arrives together, two rising edges after the edge that accepts the input: one edge registers the normalize stage and one registers the round stage. The bench drives inputs on falling edges. It checks that `out_valid` is still low at the falling edge after acceptance. It then samples all fields at the falling edge after the second rising edge. The stall scenario holds `out_ready` low for several cycles and checks at falling edges that the output is frozen and that `in_ready` is low. After releasing the stall, it checks the queued results one per cycle in order.

// File: rtl/fma_nr_pkg.sv
package fma_nr_pkg;

  localparam int NR_MANT_W = 53;
  localparam int NR_EXP_W  = 13;

  typedef struct packed {
    logic inexact;
    logic rnd_up;
    logic zero;
  } nr_flags_t;

  // nearest-even increment decision
  function automatic logic rne_up(input logic lsb, input logic g,
                                  input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

endpackage

// File: rtl/nr_lzc.sv
module nr_lzc #(
  parameter int W  = 106,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // highest set bit wins because it is visited last
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/nr_pipe_reg.sv
module nr_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) out_data <= in_data;
  end
endmodule

// File: rtl/nr_norm.sv
module nr_norm #(
  parameter int SUM_W  = 106,
  parameter int MANT_W = 53,
  parameter int EXP_W  = 13
) (
  input  logic [SUM_W-1:0]  sum,
  input  logic              xbit,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [MANT_W-1:0] sig,
  output logic              g,
  output logic              r,
  output logic              s,
  output logic [EXP_W-1:0]  exp_o,
  output logic              zero
);
  localparam int CW   = $clog2(SUM_W + 1);
  localparam int GPOS = SUM_W - 1 - MANT_W;
  localparam int RPOS = GPOS - 1;

  logic [CW-1:0]    lz;
  logic [SUM_W-1:0] shifted;

  nr_lzc #(.W(SUM_W), .CW(CW)) lzc_i (.vec(sum), .cnt(lz));

  assign shifted = sum << lz;
  assign sig     = shifted[SUM_W-1 -: MANT_W];
  assign g       = shifted[GPOS];
  assign r       = shifted[RPOS];
  // X' is kept out of the shift and only joins the sticky OR
  assign s       = (|shifted[RPOS-1:0]) | xbit;
  assign zero    = (sum == '0);
  assign exp_o   = zero ? '0 : (exp_i + EXP_W'(1) - EXP_W'(lz));
endmodule

// File: rtl/nr_round.sv
module nr_round
  import fma_nr_pkg::*;
#(
  parameter int MANT_W = 53,
  parameter int EXP_W  = 13
) (
  input  logic [MANT_W-1:0] sig_i,
  input  logic              g,
  input  logic              r,
  input  logic              s,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  input  logic              neg,
  input  logic              zero,
  output logic [MANT_W-1:0] sig_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              sign_o,
  output nr_flags_t         flags
);
  logic              up;
  logic              cy;
  logic [MANT_W-1:0] inc;

  assign up        = rne_up(sig_i[0], g, r, s);
  assign {cy, inc} = {1'b0, sig_i} + (MANT_W + 1)'(up);

  always_comb begin
    if (cy) sig_o = {1'b1, {(MANT_W-1){1'b0}}};
    else    sig_o = inc;
  end

  assign exp_o         = exp_i + EXP_W'(cy);
  assign sign_o        = zero ? 1'b0 : (sign_i ^ neg);
  assign flags.inexact = g | r | s;
  assign flags.rnd_up  = up;
  assign flags.zero    = zero;
endmodule

// File: rtl/fma_norm_round.sv
module fma_norm_round
  import fma_nr_pkg::*;
#(
  parameter int MANT_W = NR_MANT_W,
  parameter int EXP_W  = NR_EXP_W,
  parameter int SUM_W  = 2 * MANT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SUM_W-1:0]  in_sum,
  input  logic              in_xbit,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic              in_sign,
  input  logic              in_neg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MANT_W-1:0] out_sig,
  output logic [EXP_W-1:0]  out_exp,
  output logic              out_sign,
  output logic              out_guard,
  output logic              out_round,
  output logic              out_sticky,
  output logic              out_inexact,
  output logic              out_rounded_up,
  output logic              out_zero
);
  typedef struct packed {
    logic [MANT_W-1:0] sig;
    logic              g;
    logic              r;
    logic              s;
    logic [EXP_W-1:0]  exp;
    logic              sign;
    logic              neg;
    logic              zero;
  } norm_t;

  typedef struct packed {
    logic [MANT_W-1:0] sig;
    logic [EXP_W-1:0]  exp;
    logic              sign;
    logic              g;
    logic              r;
    logic              s;
    nr_flags_t         flags;
  } res_t;

  localparam int NORM_W = $bits(norm_t);
  localparam int RES_W  = $bits(res_t);

  norm_t n_d, n_q;
  res_t  r_d, r_q;
  logic  s1_valid, s1_ready;

  nr_norm #(.SUM_W(SUM_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) norm_i (
    .sum(in_sum), .xbit(in_xbit), .exp_i(in_exp),
    .sig(n_d.sig), .g(n_d.g), .r(n_d.r), .s(n_d.s),
    .exp_o(n_d.exp), .zero(n_d.zero)
  );
  assign n_d.sign = in_sign;
  assign n_d.neg  = in_neg;

  nr_pipe_reg #(.W(NORM_W)) s1_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(n_d),
    .out_valid(s1_valid), .out_ready(s1_ready), .out_data(n_q)
  );

  nr_round #(.MANT_W(MANT_W), .EXP_W(EXP_W)) round_i (
    .sig_i(n_q.sig), .g(n_q.g), .r(n_q.r), .s(n_q.s),
    .exp_i(n_q.exp), .sign_i(n_q.sign), .neg(n_q.neg), .zero(n_q.zero),
    .sig_o(r_d.sig), .exp_o(r_d.exp), .sign_o(r_d.sign), .flags(r_d.flags)
  );
  assign r_d.g = n_q.g;
  assign r_d.r = n_q.r;
  assign r_d.s = n_q.s;

  nr_pipe_reg #(.W(RES_W)) s2_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid), .in_ready(s1_ready), .in_data(r_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(r_q)
  );

  assign out_sig        = r_q.sig;
  assign out_exp        = r_q.exp;
  assign out_sign       = r_q.sign;
  assign out_guard      = r_q.g;
  assign out_round      = r_q.r;
  assign out_sticky     = r_q.s;
  assign out_inexact    = r_q.flags.inexact;
  assign out_rounded_up = r_q.flags.rnd_up;
  assign out_zero       = r_q.flags.zero;
endmodule

// File: rtl/fma_norm_round_chk.sv
module fma_norm_round_chk #(
  parameter int MANT_W = 53,
  parameter int EXP_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [MANT_W-1:0] out_sig,
  input logic [EXP_W-1:0]  out_exp,
  input logic              out_sign,
  input logic              out_guard,
  input logic              out_round,
  input logic              out_sticky,
  input logic              out_inexact,
  input logic              out_rounded_up,
  input logic              out_zero
);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sig) && $stable(out_exp)
      && $stable(out_sign) && $stable(out_inexact) && $stable(out_zero));

  // R2
  drained_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3
  lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> out_sig[MANT_W-1]);

  // R9
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> (out_sig == '0) && !out_sign && (out_exp == '0));

  // R6
  up_needs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rounded_up |-> out_guard);

  // R6
  tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_guard && !out_round && !out_sticky |-> !out_sig[0]);

  // R10
  exact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_guard && !out_round && !out_sticky |-> !out_inexact && !out_rounded_up);
endmodule

bind fma_norm_round fma_norm_round_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sig(out_sig), .out_exp(out_exp), .out_sign(out_sign),
  .out_guard(out_guard), .out_round(out_round), .out_sticky(out_sticky),
  .out_inexact(out_inexact), .out_rounded_up(out_rounded_up), .out_zero(out_zero)
);

// File: tb/fma_norm_round_tb_top.sv
`timescale 1ns/1ps
module fma_norm_round_tb_top;
  localparam int MW = 53;
  localparam int EW = 13;
  localparam int SW = 2 * MW;

  typedef struct packed {
    logic [MW-1:0] sig;
    logic [EW-1:0] exp;
    logic sign, g, r, s, inx, rup, zero;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_xbit = 1'b0, in_sign = 1'b0, in_neg = 1'b0;
  logic out_ready = 1'b1;
  logic [SW-1:0] in_sum = '0;
  logic [EW-1:0] in_exp = '0;
  logic in_ready, out_valid, out_sign, out_guard, out_round, out_sticky;
  logic out_inexact, out_rounded_up, out_zero;
  logic [MW-1:0] out_sig;
  logic [EW-1:0] out_exp;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fma_norm_round dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sum(in_sum), .in_xbit(in_xbit), .in_exp(in_exp), .in_sign(in_sign),
    .in_neg(in_neg), .out_valid(out_valid), .out_ready(out_ready),
    .out_sig(out_sig), .out_exp(out_exp), .out_sign(out_sign),
    .out_guard(out_guard), .out_round(out_round), .out_sticky(out_sticky),
    .out_inexact(out_inexact), .out_rounded_up(out_rounded_up), .out_zero(out_zero)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // expected result straight from the requirements
  function automatic res_t model(input logic [SW-1:0] sum, input logic x,
                                 input logic [EW-1:0] e, input logic sg, input logic ng);
    res_t m;
    logic [SW-1:0] t;
    logic [MW:0] w;
    m = '0;
    if (sum == '0) begin
      m.s = x; m.inx = x; m.zero = 1'b1;
      return m;
    end
    t = sum;
    m.exp = e + EW'(1);
    while (!t[SW-1]) begin
      t = t << 1;
      m.exp = m.exp - EW'(1);
    end
    m.sig = t[SW-1 -: MW];
    m.g = t[SW-1-MW];
    m.r = t[SW-2-MW];
    m.s = x;
    for (int i = 0; i < SW - 2 - MW; i++) m.s = m.s | t[i];
    m.rup = m.g & (m.r | m.s | m.sig[0]);
    w = {1'b0, m.sig} + (MW + 1)'(m.rup);
    if (w[MW]) begin
      m.sig = {1'b1, {(MW-1){1'b0}}};
      m.exp = m.exp + EW'(1);
    end else begin
      m.sig = w[MW-1:0];
    end
    m.sign = sg ^ ng;
    m.inx = m.g | m.r | m.s;
    return m;
  endfunction

  function automatic res_t grab();
    res_t q;
    q.sig = out_sig; q.exp = out_exp; q.sign = out_sign;
    q.g = out_guard; q.r = out_round; q.s = out_sticky;
    q.inx = out_inexact; q.rup = out_rounded_up; q.zero = out_zero;
    return q;
  endfunction

  task automatic cmp(input res_t got, input res_t m, input string tag);
    chk("R3", {tag, " sig"}, 128'(got.sig), 128'(m.sig));
    chk("R3", {tag, " exp"}, 128'(got.exp), 128'(m.exp));
    chk("R4", {tag, " guard"}, 128'(got.g), 128'(m.g));
    chk("R4", {tag, " round"}, 128'(got.r), 128'(m.r));
    chk("R5", {tag, " sticky"}, 128'(got.s), 128'(m.s));
    chk("R6", {tag, " rounded_up"}, 128'(got.rup), 128'(m.rup));
    chk("R8", {tag, " sign"}, 128'(got.sign), 128'(m.sign));
    chk("R9", {tag, " zero"}, 128'(got.zero), 128'(m.zero));
    chk("R10", {tag, " inexact"}, 128'(got.inx), 128'(m.inx));
  endtask

  task automatic drive(input logic [SW-1:0] sum, input logic x, input logic [EW-1:0] e,
                       input logic sg, input logic ng);
    in_valid = 1'b1; in_sum = sum; in_xbit = x; in_exp = e; in_sign = sg; in_neg = ng;
  endtask

  task automatic run_one(input logic [SW-1:0] sum, input logic x, input logic [EW-1:0] e,
                         input logic sg, input logic ng, input string tag, output res_t got);
    @(negedge clk);
    drive(sum, x, e, sg, ng);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", {tag, " not early"}, 128'(out_valid), 128'(0));
    @(posedge clk);
    @(negedge clk);
    chk("R1", {tag, " valid on time"}, 128'(out_valid), 128'(1));
    got = grab();
    cmp(got, model(sum, x, e, sg, ng), tag);
  endtask

  localparam logic [EW-1:0] E0 = EW'(1000);
  localparam logic [SW-1:0] ONE = SW'(1);

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "reset out_valid", 128'(out_valid), 128'(0));
    chk("R1", "reset in_ready", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
  endtask

  task automatic t_carry();
    res_t q;
    run_one(ONE << (SW-1), 1'b0, E0, 1'b0, 1'b0, "carry", q);
    chk("R3", "carry exp", 128'(q.exp), 128'(E0 + EW'(1)));
    chk("R10", "carry exact", 128'(q.inx), 128'(0));
  endtask

  task automatic t_left();
    res_t q;
    run_one(ONE << 60, 1'b0, E0, 1'b0, 1'b0, "left", q);
    chk("R3", "left exp", 128'(q.exp), 128'(E0 - EW'(44)));
    chk("R3", "left sig", 128'(q.sig), 128'(ONE << (MW-1)));
  endtask

  task automatic t_ties();
    res_t q;
    run_one((ONE << (SW-1)) | (ONE << (SW-1-MW)), 1'b0, E0, 1'b0, 1'b0, "tie_even", q);
    chk("R6", "tie even no up", 128'(q.rup), 128'(0));
    run_one((ONE << (SW-1)) | (ONE << (SW-MW)) | (ONE << (SW-1-MW)), 1'b0, E0, 1'b0, 1'b0,
            "tie_odd", q);
    chk("R6", "tie odd up", 128'(q.rup), 128'(1));
    chk("R6", "tie odd sig", 128'(q.sig), 128'((ONE << (MW-1)) | SW'(2)));
    run_one((ONE << (SW-1)) | (ONE << (SW-2-MW)), 1'b0, E0, 1'b0, 1'b0, "round_only", q);
    chk("R4", "round only bit", 128'({q.g, q.r}), 128'(1));
  endtask

  task automatic t_overflow();
    res_t q;
    run_one(((ONE << (MW+1)) - ONE) << (SW-1-MW), 1'b0, E0, 1'b0, 1'b0, "ovf", q);
    chk("R7", "ovf sig", 128'(q.sig), 128'(ONE << (MW-1)));
    chk("R7", "ovf exp", 128'(q.exp), 128'(E0 + EW'(2)));
  endtask

  task automatic t_xbit();
    res_t q;
    run_one((ONE << (SW-1)) | (ONE << (SW-1-MW)), 1'b1, E0, 1'b0, 1'b0, "x_tie", q);
    chk("R5", "xbit breaks tie", 128'(q.sig), 128'((ONE << (MW-1)) | ONE));
    run_one(ONE << 60, 1'b1, E0, 1'b0, 1'b0, "x_noshift", q);
    chk("R5", "xbit stays sticky", 128'({q.g, q.r, q.s}), 128'(1));
    chk("R5", "xbit not in sig", 128'(q.sig), 128'(ONE << (MW-1)));
  endtask

  task automatic t_zero();
    res_t q;
    run_one('0, 1'b0, E0, 1'b1, 1'b1, "zero", q);
    chk("R9", "zero sign", 128'(q.sign), 128'(0));
    chk("R9", "zero exp", 128'(q.exp), 128'(0));
    run_one('0, 1'b1, E0, 1'b1, 1'b0, "zero_x", q);
    chk("R9", "zero inexact", 128'(q.inx), 128'(1));
  endtask

  task automatic t_negate();
    res_t q;
    run_one(ONE << 100, 1'b0, E0, 1'b0, 1'b1, "neg_p", q);
    chk("R8", "neg of plus", 128'(q.sign), 128'(1));
    run_one(ONE << 100, 1'b0, E0, 1'b1, 1'b1, "neg_m", q);
    chk("R8", "neg of minus", 128'(q.sign), 128'(0));
    run_one(ONE << 100, 1'b0, E0, 1'b1, 1'b0, "pos_m", q);
    chk("R8", "plain minus", 128'(q.sign), 128'(1));
  endtask

  task automatic t_stall();
    logic [SW-1:0] sa, sb, sc;
    res_t ma, mb, mc;
    sa = (ONE << 90) | ONE; sb = ONE << (SW-2); sc = (ONE << 70) | (ONE << 5);
    ma = model(sa, 1'b0, E0, 1'b0, 1'b0);
    mb = model(sb, 1'b1, E0, 1'b1, 1'b0);
    mc = model(sc, 1'b0, E0, 1'b0, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    drive(sa, 1'b0, E0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    drive(sb, 1'b1, E0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    drive(sc, 1'b0, E0, 1'b0, 1'b1);
    chk("R2", "in_ready low when full", 128'(in_ready), 128'(0));
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2", "stall valid", 128'(out_valid), 128'(1));
      chk("R2", "stall held sig", 128'(out_sig), 128'(ma.sig));
      chk("R2", "stall held exp", 128'(out_exp), 128'(ma.exp));
    end
    out_ready = 1'b1;
    cmp(grab(), ma, "stall_a");
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "second valid", 128'(out_valid), 128'(1));
    cmp(grab(), mb, "stall_b");
    @(posedge clk);
    @(negedge clk);
    chk("R2", "third valid", 128'(out_valid), 128'(1));
    cmp(grab(), mc, "stall_c");
    @(posedge clk);
    @(negedge clk);
    chk("R2", "drained", 128'(out_valid), 128'(0));
  endtask

  task automatic t_sweep();
    res_t q;
    logic [127:0] raw;
    logic [SW-1:0] sm;
    for (int k = 0; k < 40; k++) begin
      raw = {$urandom, $urandom, $urandom, $urandom};
      sm = raw[SW-1:0] >> $urandom_range(0, SW);
      run_one(sm, 1'($urandom), EW'($urandom), 1'($urandom), 1'($urandom), "sweep", q);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_carry();
    t_left();
    t_ties();
    t_overflow();
    t_xbit();
    t_zero();
    t_negate();
    t_stall();
    t_sweep();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule